// File: doc/BRIEF.md
# General-Purpose I/O Port with Timer-Clock Pin Override

This block is an eight-pin bidirectional I/O port on a simple register bus. Software sets each pin's direction through a direction register, and the value driven on output pins through an output latch. Reading the port data register returns, bit by bit, either the latch (for pins set as outputs) or the synchronized pin level (for pins set as inputs).

Two pins double as external clock inputs for two timers: pin 6 feeds timer A and pin 4 feeds timer B. Each timer raises a select input when its prescaler setting picks the external clock. While a select is high, the matching pin's output driver is held off, whatever its direction bit says, and the synchronized pin level is passed to that timer. Every pin input crosses a two-flop synchronizer before it is used.

Top module: `gpio_port`

## Requirements
- R1: After reset, every direction bit and every output latch bit is 0, so `pin_oe` and `pin_out` are all zero.
- R2: A write at offset 7 loads the direction register, and a read at offset 7 returns the value written.
- R3: For a pin that no timer has claimed, `pin_oe` equals its direction bit (1 = drive the pin, 0 = input).
- R4: A write at offset 3 loads the output latch and appears on `pin_out` from the next cycle, for every pin and whatever the direction bits hold, so the latch can be preloaded before a pin turns into an output.
- R5: A read at offset 3 returns the output latch for each bit whose direction bit is 1.
- R6: A read at offset 3 returns the pin level for each bit whose direction bit is 0, delayed by two clock edges through the synchronizer.
- R7: While `tmr_a_ext_sel` is high, `pin_oe[6]` is 0; while `tmr_b_ext_sel` is high, `pin_oe[4]` is 0. The direction register keeps and reads back its value, and the port read still chooses latch or pin by the direction bit.
- R8: `tmr_a_clk` follows the synchronized level of pin 6 while `tmr_a_ext_sel` is high and is 0 otherwise; `tmr_b_clk` does the same for pin 4 and `tmr_b_ext_sel`.
- R9: Reads at any offset other than 3 and 7 return 0, and writes there change neither register.
- R10: Dropping a timer select gives its pin's output enable back to the direction bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values (output latch) |
| pin_oe | output | 8 | Pad output enables |
| tmr_a_ext_sel | input | 1 | Timer A picks external clock on pin 6 |
| tmr_b_ext_sel | input | 1 | Timer B picks external clock on pin 4 |
| tmr_a_clk | output | 1 | Synchronized timer A clock level |
| tmr_b_clk | output | 1 | Synchronized timer B clock level |

## Verification
All 256 direction values are swept with a latch value and a pin pattern that are each different functions of the direction, so every bit of a port read separates the latch path from the pin path and a swapped or missing select shows up. The four combinations of the two timer selects are then tried with all direction bits set, which tells a correct override of pins 6 and 4 apart from one on the wrong pin or one that also corrupts the stored direction. Toggling pins 6 and 4 under each select checks that the timer clocks follow the pin only when claimed, and writes and reads at the six unmapped offsets show that they neither read nor change anything.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int CLKA_BIT = 6;
    localparam int CLKB_BIT = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(7);

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_DATA = 2'd1,
        RSEL_DIR  = 2'd2
    } reg_sel_t;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
    } port_regs_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        if (a == OFS_DATA)     return RSEL_DATA;
        else if (a == OFS_DIR) return RSEL_DIR;
        else                   return RSEL_NONE;
    endfunction

    // Pins claimed by a timer as clock inputs.
    function automatic logic [PORT_W-1:0] claim_mask(input logic sel_a, input logic sel_b);
        logic [PORT_W-1:0] m;
        m = '0;
        m[CLKA_BIT] = sel_a;
        m[CLKB_BIT] = sel_b;
        return m;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_t          rsel,
    input  logic [PORT_W-1:0] wdata,
    output port_regs_t        regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (we) begin
            case (rsel)
                RSEL_DATA: regs.latch <= wdata;
                RSEL_DIR:  regs.dir   <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux
    import gpio_pkg::*;
(
    input  port_regs_t        regs,
    input  logic [PORT_W-1:0] pin_sync,
    input  reg_sel_t          rsel,
    input  logic              sel_a,
    input  logic              sel_b,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] rdata,
    output logic              clk_a,
    output logic              clk_b
);
    logic [PORT_W-1:0] claimed;
    logic [PORT_W-1:0] port_view;

    always_comb begin
        claimed   = claim_mask(sel_a, sel_b);
        pin_out   = regs.latch;
        pin_oe    = regs.dir & ~claimed;
        port_view = (regs.dir & regs.latch) | (~regs.dir & pin_sync);
        case (rsel)
            RSEL_DATA: rdata = port_view;
            RSEL_DIR:  rdata = regs.dir;
            default:   rdata = '0;
        endcase
        clk_a = sel_a & pin_sync[CLKA_BIT];
        clk_b = sel_b & pin_sync[CLKB_BIT];
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    input  logic              tmr_a_ext_sel,
    input  logic              tmr_b_ext_sel,
    output logic              tmr_a_clk,
    output logic              tmr_b_clk
);
    reg_sel_t          rsel;
    port_regs_t        regs;
    logic [PORT_W-1:0] pin_sync;

    assign rsel = decode_addr(bus_addr);

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .rsel(rsel),
        .wdata(bus_wdata), .regs(regs)
    );

    gpio_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
    );

    gpio_mux u_mux (
        .regs(regs), .pin_sync(pin_sync), .rsel(rsel),
        .sel_a(tmr_a_ext_sel), .sel_b(tmr_b_ext_sel),
        .pin_out(pin_out), .pin_oe(pin_oe), .rdata(bus_rdata),
        .clk_a(tmr_a_clk), .clk_b(tmr_b_clk)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic              tmr_a_ext_sel,
    input logic              tmr_b_ext_sel,
    input logic              tmr_a_clk,
    input logic              tmr_b_clk
);
    // R4
    a_r4_latch_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DATA) |=> pin_out == $past(bus_wdata));

    // R3
    a_r3_oe_from_dir: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DIR) |=>
        (tmr_a_ext_sel || tmr_b_ext_sel || pin_oe == $past(bus_wdata)));

    // R7
    a_r7_claim_a: assert property (@(posedge clk) disable iff (rst)
        tmr_a_ext_sel |-> !pin_oe[CLKA_BIT]);
    a_r7_claim_b: assert property (@(posedge clk) disable iff (rst)
        tmr_b_ext_sel |-> !pin_oe[CLKB_BIT]);

    // R8
    a_r8_idle_clocks: assert property (@(posedge clk) disable iff (rst)
        (!tmr_a_ext_sel |-> !tmr_a_clk) and (!tmr_b_ext_sel |-> !tmr_b_clk));

    // R9
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != OFS_DATA && bus_addr != OFS_DIR) |-> bus_rdata == '0);

    // R2
    a_r2_dir_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DIR) ##1 (bus_addr == OFS_DIR) |-> bus_rdata == $past(bus_wdata));
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .tmr_a_ext_sel(tmr_a_ext_sel), .tmr_b_ext_sel(tmr_b_ext_sel),
    .tmr_a_clk(tmr_a_clk), .tmr_b_clk(tmr_b_clk)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;
    logic       sel_a = 1'b0, sel_b = 1'b0;
    logic       tclk_a, tclk_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .tmr_a_ext_sel(sel_a),
        .tmr_b_ext_sel(sel_b), .tmr_a_clk(tclk_a), .tmr_b_clk(tclk_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Pins applied at a falling edge become visible after two rising edges.
    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v, lat, pins;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        rd(3'd7, v); check("R1 dir", v, 8'h00);

        // R4 preload while all pins are inputs
        wr(3'd3, 8'hC3);
        check("R4 preload", pin_out, 8'hC3);
        check("R4 oe stays off", pin_oe, 8'h00);

        // Sweep all direction values: R2 R3 R4 R5 R6
        for (int d = 0; d < 256; d++) begin
            lat  = 8'(d) ^ 8'h5A;
            pins = ~(8'(d) * 8'd37);
            wr(3'd7, 8'(d));
            wr(3'd3, lat);
            set_pins(pins);
            rd(3'd7, v); check("R2 dir readback", v, 8'(d));
            check("R3 oe", pin_oe, 8'(d));
            check("R4 out", pin_out, lat);
            rd(3'd3, v);
            check("R5 latch bits", v & 8'(d), lat & 8'(d));
            check("R6 pin bits", v & ~8'(d), pins & ~8'(d));
        end

        // R6 synchronizer latency: not visible after one edge
        wr(3'd7, 8'h00);
        set_pins(8'h00);
        @(negedge clk); pin_in = 8'hFF;
        @(negedge clk); rd(3'd3, v); check("R6 one edge", v, 8'h00);
        @(negedge clk); rd(3'd3, v); check("R6 two edges", v, 8'hFF);

        // R7 R10 override across select combinations
        wr(3'd7, 8'hFF);
        wr(3'd3, 8'h00);
        set_pins(8'hFF);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            sel_a = s[0]; sel_b = s[1];
            #1;
            check("R7 oe override", pin_oe,
                  8'hFF & ~({1'b0, s[0], 1'b0, s[1], 4'h0}));
            rd(3'd7, v); check("R7 dir kept", v, 8'hFF);
            rd(3'd3, v); check("R7 read uses dir", v, 8'h00);
        end
        @(negedge clk); sel_a = 1'b0; sel_b = 1'b0; #1;
        check("R10 release", pin_oe, 8'hFF);

        // R8 timer clocks follow pins only when selected
        for (int s = 0; s < 4; s++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                @(negedge clk); sel_a = s[0]; sel_b = s[1];
                set_pins(lvl[0] ? 8'h50 : 8'h00);
                check("R8 clk a", {7'd0, tclk_a}, {7'd0, s[0] & lvl[0]});
                check("R8 clk b", {7'd0, tclk_b}, {7'd0, s[1] & lvl[0]});
            end
        end
        @(negedge clk); sel_a = 1'b0; sel_b = 1'b0;

        // R9 unmapped offsets
        wr(3'd7, 8'h0F);
        wr(3'd3, 8'h33);
        for (int a = 0; a < 8; a++) begin
            if (a == 3 || a == 7) continue;
            wr(3'(a), 8'hFF);
            rd(3'(a), v); check("R9 read zero", v, 8'h00);
        end
        rd(3'd7, v); check("R9 dir untouched", v, 8'h0F);
        check("R9 latch untouched", pin_out, 8'h33);

        // R1 reset again clears registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 oe after reset", pin_oe, 8'h00);
        check("R1 out after reset", pin_out, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule